// File: doc/BRIEF.md
# Video Line and Frame Timing Generator

This block derives video line and frame timing from the processor clock. A 60 Hz and a 50 Hz raster differ in line count and in line length. Neither line length is a whole number of processor clocks, so the block adds a fixed-point step with 12 fraction bits to a running phase once per line. The integer part of that sum sets how many clocks the line lasts, and the fraction carries into the next line. Over many lines the average line length therefore matches the fractional value.

A line counter advances on every line boundary and wraps at the end of the frame. Vertical blank is raised from a configurable line until the frame wraps. A field bit flips once per frame. When interlace is enabled, the field bit is also shown on a status output. The line pulse lasts one clock and can serve as the external tick of a timer channel. The standard select input is only taken at a frame wrap, so no frame mixes the two standards.

Top module: `vtg_timing_gen`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `line_pulse`, `frame_start`, `vblank`, `field_odd`, `field_status` and `line_idx` are all zero. The active standard returns to 60 Hz (select value 0) whatever `std_sel` holds.
- R2: Let S_k be the sum of the per-line steps of the first k lines after reset. `line_pulse` is high for exactly the one cycle that follows clock edge floor(S_k / 4096) - 1, counting edges from 0 after reset release. The step is `STEP_STD0` (8791293 by default) when the standard is 0 and `STEP_STD1` (8864320) when it is 1.
- R3: `line_idx` counts line boundaries and returns to 0 after line `LINES_STD0`-1 (263 lines) or `LINES_STD1`-1 (314 lines). `frame_start` is high for one cycle, exactly when the wrapping line pulse is high.
- R4: `vblank` is high exactly while `line_idx` is at least `VBLANK_LINE` (240 by default).
- R5: `field_odd` inverts at every frame wrap and never changes otherwise.
- R6: `std_sel` (0 = 60 Hz, 1 = 50 Hz) is sampled only on the clock edge of a frame wrap. It selects both the line count and the step for the whole next frame. Changes between wraps have no effect.
- R7: `field_status` equals `field_odd` while `interlace_en` is 1 and is 0 while it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst | input | 1 | Synchronous active-high reset |
| std_sel | input | 1 | Requested standard, 0 = 60 Hz, 1 = 50 Hz |
| interlace_en | input | 1 | Shows the field bit on `field_status` |
| line_pulse | output | 1 | One-cycle pulse at each line boundary |
| frame_start | output | 1 | One-cycle pulse when the line counter wraps |
| vblank | output | 1 | Vertical blank flag |
| field_odd | output | 1 | Field bit, flips each frame |
| field_status | output | 1 | Field bit gated by `interlace_en` |
| line_idx | output | LINE_W | Current line number |

## Verification
Several events can land on the same clock edge. The last line boundary of a frame also wraps the line counter, drops vertical blank, flips the field bit and latches a new standard. The first line of the following frame must then already use the new step. The bench runs a small configuration (7 and 9 lines, steps near 3.3 and 4.2 clocks). It toggles `std_sel` at periods unrelated to the frame length, so a standard change often meets a wrap edge or falls in the middle of a frame. Every cycle is compared with boundary times computed from the running sum of steps, and a mid-run reset is also covered.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

    typedef enum logic {
        VSTD_60HZ = 1'b0,
        VSTD_50HZ = 1'b1
    } vstd_e;

    typedef struct packed {
        logic line_pulse;
        logic frame_start;
        logic vblank;
        logic field;
    } vtg_flags_t;

    function automatic int unsigned pick_by_std(vstd_e s, int unsigned v60, int unsigned v50);
        return (s == VSTD_50HZ) ? v50 : v60;
    endfunction

endpackage

// File: rtl/vtg_line_phase.sv
module vtg_line_phase
    import vtg_pkg::*;
#(
    parameter int unsigned FRAC_W = 12,
    parameter int unsigned STEP_W = 32,
    parameter int unsigned STEP_A = 8791293,
    parameter int unsigned STEP_B = 8864320
) (
    input  logic  clk,
    input  logic  rst,
    input  vstd_e std_cur,
    output logic  line_tick
);
    localparam int unsigned SUM_W = STEP_W + 1;
    localparam int unsigned LEN_W = SUM_W - FRAC_W;

    logic [FRAC_W-1:0] frac_q;
    logic [LEN_W-1:0]  pos_q;
    logic [LEN_W-1:0]  len_w;
    logic [STEP_W-1:0] step_w;
    logic [SUM_W-1:0]  sum_w;

    always_comb begin
        step_w    = STEP_W'(pick_by_std(std_cur, STEP_A, STEP_B));
        sum_w     = SUM_W'(frac_q) + SUM_W'(step_w);
        len_w     = sum_w[SUM_W-1:FRAC_W];
        line_tick = (pos_q == len_w - LEN_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            frac_q <= '0;
            pos_q  <= '0;
        end else if (line_tick) begin
            frac_q <= sum_w[FRAC_W-1:0];
            pos_q  <= '0;
        end else begin
            pos_q  <= pos_q + LEN_W'(1);
        end
    end

    AST_POS_BELOW_LEN: assert property (@(posedge clk) disable iff (rst)
        pos_q < len_w);  // R2

endmodule

// File: rtl/vtg_frame_seq.sv
module vtg_frame_seq
    import vtg_pkg::*;
#(
    parameter int unsigned LINE_W      = 9,
    parameter int unsigned LINES_A     = 263,
    parameter int unsigned LINES_B     = 314,
    parameter int unsigned VBLANK_LINE = 240
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_tick,
    input  vstd_e             std_req,
    output vstd_e             std_cur,
    output logic [LINE_W-1:0] line_idx,
    output vtg_flags_t        flags
);
    vstd_e             std_q;
    logic [LINE_W-1:0] line_q;
    logic [LINE_W-1:0] lines_cur;
    logic [LINE_W-1:0] line_next;
    logic              at_last;
    vtg_flags_t        flags_q;

    always_comb begin
        lines_cur = LINE_W'(pick_by_std(std_q, LINES_A, LINES_B));
        at_last   = (line_q == lines_cur - LINE_W'(1));
        line_next = at_last ? '0 : line_q + LINE_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            std_q   <= VSTD_60HZ;
            line_q  <= '0;
            flags_q <= '0;
        end else begin
            flags_q.line_pulse  <= line_tick;
            flags_q.frame_start <= line_tick && at_last;
            if (line_tick) begin
                line_q         <= line_next;
                flags_q.vblank <= (line_next >= LINE_W'(VBLANK_LINE));
                if (at_last) begin
                    flags_q.field <= ~flags_q.field;
                    std_q         <= std_req;
                end
            end
        end
    end

    assign std_cur  = std_q;
    assign line_idx = line_q;
    assign flags    = flags_q;

    AST_LINE_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
        line_q < lines_cur);  // R3
    AST_FRAME_NEEDS_LINE: assert property (@(posedge clk) disable iff (rst)
        flags_q.frame_start |-> flags_q.line_pulse);  // R3
    AST_VBLANK_TRACKS_LINE: assert property (@(posedge clk) disable iff (rst)
        flags_q.vblank == (line_q >= LINE_W'(VBLANK_LINE)));  // R4
    AST_FIELD_ONLY_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
        !$stable(flags_q.field) |-> flags_q.frame_start);  // R5
    AST_STD_ONLY_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
        !$stable(std_q) |-> flags_q.frame_start);  // R6

endmodule

// File: rtl/vtg_timing_gen.sv
module vtg_timing_gen
    import vtg_pkg::*;
#(
    parameter int unsigned FRAC_W      = 12,
    parameter int unsigned STEP_W      = 32,
    parameter int unsigned STEP_STD0   = 8791293,
    parameter int unsigned STEP_STD1   = 8864320,
    parameter int unsigned LINES_STD0  = 263,
    parameter int unsigned LINES_STD1  = 314,
    parameter int unsigned VBLANK_LINE = 240,
    parameter int unsigned LINE_W      = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              std_sel,
    input  logic              interlace_en,
    output logic              line_pulse,
    output logic              frame_start,
    output logic              vblank,
    output logic              field_odd,
    output logic              field_status,
    output logic [LINE_W-1:0] line_idx
);
    vstd_e      std_cur;
    logic       line_tick;
    vtg_flags_t flags;

    vtg_line_phase #(
        .FRAC_W (FRAC_W),
        .STEP_W (STEP_W),
        .STEP_A (STEP_STD0),
        .STEP_B (STEP_STD1)
    ) u_phase (
        .clk       (clk),
        .rst       (rst),
        .std_cur   (std_cur),
        .line_tick (line_tick)
    );

    vtg_frame_seq #(
        .LINE_W      (LINE_W),
        .LINES_A     (LINES_STD0),
        .LINES_B     (LINES_STD1),
        .VBLANK_LINE (VBLANK_LINE)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .line_tick (line_tick),
        .std_req   (vstd_e'(std_sel)),
        .std_cur   (std_cur),
        .line_idx  (line_idx),
        .flags     (flags)
    );

    assign line_pulse   = flags.line_pulse;
    assign frame_start  = flags.frame_start;
    assign vblank       = flags.vblank;
    assign field_odd    = flags.field;
    assign field_status = flags.field & interlace_en;

    AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        line_pulse |=> !line_pulse);  // R2
    AST_STATUS_FOLLOWS_FIELD: assert property (@(posedge clk) disable iff (rst)
        (interlace_en && !rst) |-> (field_status == field_odd));  // R7

endmodule

// File: tb/vtg_timing_gen_test.sv
module vtg_timing_gen_test;
    localparam int CLK_PERIOD = 10;
    localparam int STEP0 = 13522;
    localparam int STEP1 = 17084;
    localparam int LINES0 = 7;
    localparam int LINES1 = 9;
    localparam int VBL = 5;
    localparam int LW = 9;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic std_sel = 1'b0;
    logic interlace_en = 1'b0;
    logic line_pulse, frame_start, vblank, field_odd, field_status;
    logic [LW-1:0] line_idx;

    int checks = 0;
    int failures = 0;

    // model state
    longint m_sum;
    int m_std, m_line, m_field, m_pulse, m_frame;

    always #(CLK_PERIOD/2) clk = ~clk;

    vtg_timing_gen #(
        .FRAC_W(12), .STEP_W(32),
        .STEP_STD0(STEP0), .STEP_STD1(STEP1),
        .LINES_STD0(LINES0), .LINES_STD1(LINES1),
        .VBLANK_LINE(VBL), .LINE_W(LW)
    ) uut (
        .clk(clk), .rst(rst), .std_sel(std_sel), .interlace_en(interlace_en),
        .line_pulse(line_pulse), .frame_start(frame_start), .vblank(vblank),
        .field_odd(field_odd), .field_status(field_status), .line_idx(line_idx)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic chk_all_zero(input string req);
        chk(req, "line_pulse", int'(line_pulse), 0);
        chk(req, "frame_start", int'(frame_start), 0);
        chk(req, "vblank", int'(vblank), 0);
        chk(req, "field_odd", int'(field_odd), 0);
        chk(req, "field_status", int'(field_status), 0);
        chk(req, "line_idx", int'(line_idx), 0);
    endtask

    function automatic int step_of(input int s);
        return (s == 1) ? STEP1 : STEP0;
    endfunction

    function automatic int lines_of(input int s);
        return (s == 1) ? LINES1 : LINES0;
    endfunction

    // mode 0: select flips every 23 cycles; mode 1: 50 Hz first, then flips every 61
    task automatic run_phase(input int n, input int mode);
        m_sum = 0; m_std = 0; m_line = 0; m_field = 0;
        for (int e = 0; e < n; e++) begin
            if (mode == 0) begin
                std_sel      = ((e / 23) % 2) == 1;
                interlace_en = ((e / 50) % 2) == 1;
            end else begin
                std_sel      = (e < 150) ? 1'b1 : (((e / 61) % 2) == 0);
                interlace_en = ((e / 37) % 3) != 0;
            end
            @(posedge clk);
            m_pulse = 0; m_frame = 0;
            if (longint'(e + 1) == ((m_sum + longint'(step_of(m_std))) >>> 12)) begin
                m_pulse = 1;
                m_sum += longint'(step_of(m_std));
                m_line++;
                if (m_line == lines_of(m_std)) begin
                    m_line  = 0;
                    m_frame = 1;
                    m_field ^= 1;
                    m_std   = int'(std_sel);
                end
            end
            @(negedge clk);
            chk("R2 R6", "line_pulse", int'(line_pulse), m_pulse);
            chk("R3", "frame_start", int'(frame_start), m_frame);
            chk("R3 R6", "line_idx", int'(line_idx), m_line);
            chk("R4", "vblank", int'(vblank), (m_line >= VBL) ? 1 : 0);
            chk("R5", "field_odd", int'(field_odd), m_field);
            chk("R7", "field_status", int'(field_status), interlace_en ? m_field : 0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        $display("FAIL watchdog expired at %0t", $time);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1; std_sel = 1'b1; interlace_en = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk_all_zero("R1");
        rst = 1'b0;
        run_phase(1500, 0);

        // reset in the middle of a run, select held at 50 Hz during it
        rst = 1'b1; std_sel = 1'b1; interlace_en = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk_all_zero("R1");
        rst = 1'b0;
        run_phase(1200, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule